// File: doc/BRIEF.md
# Out-of-Order Result Reordering Buffer

A circular buffer that keeps in-flight instructions of a speculative out-of-order core in program order. Decode writes an instruction into the slot at the tail. The slot index is handed back as the tag that later instructions use to name this result. Each slot holds the instruction fields, two operand slots, a result and a lifecycle state. The five states are free, waiting, issued, squashed and finished.

Instructions whose operands are both values are offered to one of two execution ports, ALU or memory, oldest first. Results come back on a set of writeback ports. Each result finishes its producer slot and is also broadcast to every waiting slot whose operand still carries the matching tag. The head slot retires once it is finished, which drives a register-file write or permits a store. A branch misprediction squashes every slot younger than the mispredicted one. Squashed slots drain through the head without any retirement write.

The depth must be a power of two. Each state change is one atomic update per clock edge.

Top module: `rob_core`

## Requirements
- R1: After reset the buffer is empty: `insReady`=1, `aluValid`=0, `memValid`=0, `cmtValid`=0 and `insTag`=0.
- R2: An accepted insert (`insValid` and `insReady`) fills the slot numbered `insTag` and advances `insTag` by one, modulo DEPTH.
- R3: The buffer holds at most DEPTH-1 instructions. With DEPTH-1 occupied, `insReady` is 0, an insert attempt is dropped, `insTag` stays unchanged and no extra instruction is ever issued.
- R4: A waiting instruction is offered only when both operand slots hold values (`srcNIsTag`=0 means value, 1 means tag). It goes on the ALU port when `insIsMem`=0 and on the memory port when `insIsMem`=1. The oldest ready instruction counted from the head is offered first, and once issued it is not offered again.
- R5: A writeback (`wbValid[w]`, `wbTag[w]`, `wbData[w]`) to an issued slot stores the result and finishes it. In the same edge, every waiting operand slot that holds tag `wbTag[w]` is replaced by `wbData[w]`.
- R6: When an insert names a source tag that a writeback delivers in the same cycle, the inserted operand captures the written value rather than the tag.
- R7: Retirement is in program order. `cmtValid` is 1 only while the head slot is finished, and it shows that slot's `cmtDest`, `cmtData` and `cmtIsStore`. A finished younger slot waits behind an unfinished head.
- R8: `killValid` with `killTag` squashes every occupied slot strictly younger than `killTag` and forces `insReady` to 0 in that cycle. Squashed slots are never issued, ignore writebacks and leave through the head without raising `cmtValid`.
- R9: An offered instruction is issued only on a cycle where its port's ready input is 1. Otherwise it stays offered with the same tag and operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| insValid | input | 1 | Insert request from decode |
| insIsMem | input | 1 | 1 = memory instruction, 0 = ALU instruction |
| insIsStore | input | 1 | Memory instruction is a store |
| insDest | input | REG_W | Destination register index |
| insOpcode | input | OPC_W | Operation code |
| src1IsTag | input | 1 | Operand 1 is a tag rather than a value |
| src1Tag | input | IDX_W | Producer slot of operand 1 |
| src1Val | input | DATA_W | Value of operand 1 |
| src2IsTag | input | 1 | Operand 2 is a tag rather than a value |
| src2Tag | input | IDX_W | Producer slot of operand 2 |
| src2Val | input | DATA_W | Value of operand 2 |
| insReady | output | 1 | Insert will be accepted |
| insTag | output | IDX_W | Slot the next insert takes (tail) |
| aluValid | output | 1 | ALU instruction offered |
| aluReady | input | 1 | ALU unit accepts |
| aluTag | output | IDX_W | Slot of offered ALU instruction |
| aluOpcode | output | OPC_W | Its opcode |
| aluOp1 | output | DATA_W | Its operand 1 |
| aluOp2 | output | DATA_W | Its operand 2 |
| memValid | output | 1 | Memory instruction offered |
| memReady | input | 1 | Memory unit accepts |
| memTag | output | IDX_W | Slot of offered memory instruction |
| memOpcode | output | OPC_W | Its opcode |
| memOp1 | output | DATA_W | Its operand 1 |
| memOp2 | output | DATA_W | Its operand 2 |
| memIsStore | output | 1 | Offered memory instruction is a store |
| wbValid | input | NUM_WB | Writeback valid per port |
| wbTag | input | NUM_WB x IDX_W | Writeback producer slot per port |
| wbData | input | NUM_WB x DATA_W | Writeback result per port |
| cmtValid | output | 1 | Head retires with a write this cycle |
| cmtDest | output | REG_W | Retiring destination register |
| cmtData | output | DATA_W | Retiring result |
| cmtIsStore | output | 1 | Retiring instruction is a store |
| killValid | input | 1 | Branch misprediction |
| killTag | input | IDX_W | Slot of the mispredicted branch |

## Verification
Slot state shows at the ports in one of three ways: an instruction offered or withheld on an issue port, an operand value on that port, or a retirement record. A slot left waiting after its producer wrote back never issues. A missed tag broadcast leaves a dependent instruction withheld from the cycle after the writeback. A slot that escapes a squash reaches an issue port at once, or it produces a retirement that the scoreboard does not expect as soon as it reaches the head. A pointer error shows on `insTag` one cycle after the insert. It also shows as retirements out of program order, which the scoreboard catches on the first retiring instruction.

// File: rtl/rob_pkg.sv
package rob_pkg;

  typedef enum logic [2:0] {
    ENT_FREE     = 3'd0,
    ENT_WAIT     = 3'd1,
    ENT_ISSUED   = 3'd2,
    ENT_SQUASHED = 3'd3,
    ENT_FINISHED = 3'd4
  } entState_e;

  // Strobes from control to datapath, one per atomic operation
  typedef struct packed {
    logic insEn;
    logic aluEn;
    logic memEn;
    logic retireEn;
  } robStrobe_t;

endpackage

// File: rtl/rob_ctrl.sv
module rob_ctrl
  import rob_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             insValid,
  input  logic             killValid,
  input  logic [IDX_W-1:0] killTag,
  input  logic [DEPTH-1:0] aluCand,
  input  logic [DEPTH-1:0] memCand,
  input  logic             aluReady,
  input  logic             memReady,
  input  entState_e        headState,
  output robStrobe_t       st,
  output logic [IDX_W-1:0] tailPtr,
  output logic [IDX_W-1:0] headPtr,
  output logic [IDX_W-1:0] aluPick,
  output logic [IDX_W-1:0] memPick,
  output logic             aluAvail,
  output logic             memAvail,
  output logic [DEPTH-1:0] killMask,
  output logic             insReady,
  output logic             commitNow
);

  logic [IDX_W-1:0] nextTail;
  logic [IDX_W-1:0] occupied;
  logic [IDX_W-1:0] killOff;
  logic             isFull;

  assign nextTail = tailPtr + IDX_W'(1);
  assign isFull   = (nextTail == headPtr);
  assign occupied = tailPtr - headPtr;
  assign killOff  = killTag - headPtr;
  assign insReady = !isFull && !killValid;

  // Squash mask: occupied slots strictly younger than the branch
  always_comb begin
    logic [IDX_W-1:0] off;
    for (int i = 0; i < DEPTH; i++) begin
      off = IDX_W'(i) - headPtr;
      killMask[i] = killValid && (off > killOff) && (off < occupied);
    end
  end

  // Oldest-first selection counted from the head
  always_comb begin
    logic [IDX_W-1:0] idx;
    aluAvail = 1'b0;
    memAvail = 1'b0;
    aluPick  = headPtr;
    memPick  = headPtr;
    for (int k = 0; k < DEPTH; k++) begin
      idx = headPtr + IDX_W'(k);
      if (!aluAvail && aluCand[idx]) begin
        aluAvail = 1'b1;
        aluPick  = idx;
      end
      if (!memAvail && memCand[idx]) begin
        memAvail = 1'b1;
        memPick  = idx;
      end
    end
  end

  assign commitNow   = (headState == ENT_FINISHED);
  assign st.insEn    = insValid && insReady;
  assign st.aluEn    = aluAvail && aluReady;
  assign st.memEn    = memAvail && memReady;
  assign st.retireEn = (headState == ENT_FINISHED) || (headState == ENT_SQUASHED);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tailPtr <= '0;
      headPtr <= '0;
    end else begin
      if (st.insEn)    tailPtr <= nextTail;
      if (st.retireEn) headPtr <= headPtr + IDX_W'(1);
    end
  end

endmodule

// File: rtl/rob_dp.sv
module rob_dp
  import rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 16,
  parameter int REG_W  = 5,
  parameter int OPC_W  = 6,
  parameter int NUM_WB = 2,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  robStrobe_t                     st,
  input  logic [IDX_W-1:0]               tailPtr,
  input  logic [IDX_W-1:0]               headPtr,
  input  logic [IDX_W-1:0]               aluPick,
  input  logic [IDX_W-1:0]               memPick,
  input  logic [DEPTH-1:0]               killMask,
  input  logic                           insIsMem,
  input  logic                           insIsStore,
  input  logic [REG_W-1:0]               insDest,
  input  logic [OPC_W-1:0]               insOpcode,
  input  logic                           src1IsTag,
  input  logic [IDX_W-1:0]               src1Tag,
  input  logic [DATA_W-1:0]              src1Val,
  input  logic                           src2IsTag,
  input  logic [IDX_W-1:0]               src2Tag,
  input  logic [DATA_W-1:0]              src2Val,
  input  logic [NUM_WB-1:0]              wbValid,
  input  logic [NUM_WB-1:0][IDX_W-1:0]   wbTag,
  input  logic [NUM_WB-1:0][DATA_W-1:0]  wbData,
  output logic [DEPTH-1:0]               aluCand,
  output logic [DEPTH-1:0]               memCand,
  output entState_e                      headState,
  output logic [OPC_W-1:0]               aluOpcode,
  output logic [DATA_W-1:0]              aluOp1,
  output logic [DATA_W-1:0]              aluOp2,
  output logic [OPC_W-1:0]               memOpcode,
  output logic [DATA_W-1:0]              memOp1,
  output logic [DATA_W-1:0]              memOp2,
  output logic                           memIsStore,
  output logic [REG_W-1:0]               cmtDest,
  output logic [DATA_W-1:0]              cmtData,
  output logic                           cmtIsStore
);

  entState_e         entSt    [DEPTH];
  logic              entMem   [DEPTH];
  logic              entStore [DEPTH];
  logic [REG_W-1:0]  entDest  [DEPTH];
  logic [OPC_W-1:0]  entOpc   [DEPTH];
  logic              op1Tagged[DEPTH];
  logic [IDX_W-1:0]  op1Tag   [DEPTH];
  logic [DATA_W-1:0] op1Val   [DEPTH];
  logic              op2Tagged[DEPTH];
  logic [IDX_W-1:0]  op2Tag   [DEPTH];
  logic [DATA_W-1:0] op2Val   [DEPTH];
  logic [DATA_W-1:0] entRes   [DEPTH];

  logic              resHit   [DEPTH];
  logic [DATA_W-1:0] resVal   [DEPTH];
  logic [DATA_W:0]   ins1Fwd, ins2Fwd;

  // Replace a tag by a value broadcast this cycle; returns {stillTag, value}
  function automatic logic [DATA_W:0] fwd(input logic isTag,
                                          input logic [IDX_W-1:0] tg,
                                          input logic [DATA_W-1:0] v);
    logic [DATA_W:0] r;
    r = {isTag, v};
    for (int w = 0; w < NUM_WB; w++)
      if (isTag && wbValid[w] && (wbTag[w] == tg)) r = {1'b0, wbData[w]};
    return r;
  endfunction

  always_comb begin
    ins1Fwd = fwd(src1IsTag, src1Tag, src1Val);
    ins2Fwd = fwd(src2IsTag, src2Tag, src2Val);
  end

  always_comb begin
    for (int e = 0; e < DEPTH; e++) begin
      resHit[e] = 1'b0;
      resVal[e] = '0;
      for (int w = 0; w < NUM_WB; w++)
        if (wbValid[w] && (wbTag[w] == IDX_W'(e))) begin
          resHit[e] = 1'b1;
          resVal[e] = wbData[w];
        end
    end
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_cand
      logic opsReady;
      assign opsReady   = (entSt[g] == ENT_WAIT) && !op1Tagged[g] && !op2Tagged[g];
      assign aluCand[g] = opsReady && !entMem[g];
      assign memCand[g] = opsReady &&  entMem[g];
    end
  endgenerate

  // Lifecycle state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int e = 0; e < DEPTH; e++) entSt[e] <= ENT_FREE;
    end else begin
      for (int e = 0; e < DEPTH; e++) begin
        if (st.insEn && tailPtr == IDX_W'(e))
          entSt[e] <= ENT_WAIT;
        else if (killMask[e])
          entSt[e] <= ENT_SQUASHED;
        else if (st.retireEn && headPtr == IDX_W'(e))
          entSt[e] <= ENT_FREE;
        else if ((st.aluEn && aluPick == IDX_W'(e)) || (st.memEn && memPick == IDX_W'(e)))
          entSt[e] <= ENT_ISSUED;
        else if (entSt[e] == ENT_ISSUED && resHit[e])
          entSt[e] <= ENT_FINISHED;
      end
    end
  end

  // Payload: loaded at insert, operands snooped while waiting
  always_ff @(posedge clk) begin
    for (int e = 0; e < DEPTH; e++) begin
      if (st.insEn && tailPtr == IDX_W'(e)) begin
        entMem[e]    <= insIsMem;
        entStore[e]  <= insIsStore;
        entDest[e]   <= insDest;
        entOpc[e]    <= insOpcode;
        op1Tag[e]    <= src1Tag;
        op2Tag[e]    <= src2Tag;
        {op1Tagged[e], op1Val[e]} <= ins1Fwd;
        {op2Tagged[e], op2Val[e]} <= ins2Fwd;
      end else if (entSt[e] == ENT_WAIT) begin
        {op1Tagged[e], op1Val[e]} <= fwd(op1Tagged[e], op1Tag[e], op1Val[e]);
        {op2Tagged[e], op2Val[e]} <= fwd(op2Tagged[e], op2Tag[e], op2Val[e]);
      end
      if (entSt[e] == ENT_ISSUED && resHit[e] && !killMask[e])
        entRes[e] <= resVal[e];
    end
  end

  assign headState  = entSt[headPtr];
  assign aluOpcode  = entOpc[aluPick];
  assign aluOp1     = op1Val[aluPick];
  assign aluOp2     = op2Val[aluPick];
  assign memOpcode  = entOpc[memPick];
  assign memOp1     = op1Val[memPick];
  assign memOp2     = op2Val[memPick];
  assign memIsStore = entStore[memPick];
  assign cmtDest    = entDest[headPtr];
  assign cmtData    = entRes[headPtr];
  assign cmtIsStore = entStore[headPtr];

endmodule

// File: rtl/rob_core.sv
module rob_core
  import rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 16,
  parameter int REG_W  = 5,
  parameter int OPC_W  = 6,
  parameter int NUM_WB = 2
) (
  input  logic                                     clk,
  input  logic                                     rstN,
  input  logic                                     insValid,
  input  logic                                     insIsMem,
  input  logic                                     insIsStore,
  input  logic [REG_W-1:0]                         insDest,
  input  logic [OPC_W-1:0]                         insOpcode,
  input  logic                                     src1IsTag,
  input  logic [$clog2(DEPTH)-1:0]                 src1Tag,
  input  logic [DATA_W-1:0]                        src1Val,
  input  logic                                     src2IsTag,
  input  logic [$clog2(DEPTH)-1:0]                 src2Tag,
  input  logic [DATA_W-1:0]                        src2Val,
  output logic                                     insReady,
  output logic [$clog2(DEPTH)-1:0]                 insTag,
  output logic                                     aluValid,
  input  logic                                     aluReady,
  output logic [$clog2(DEPTH)-1:0]                 aluTag,
  output logic [OPC_W-1:0]                         aluOpcode,
  output logic [DATA_W-1:0]                        aluOp1,
  output logic [DATA_W-1:0]                        aluOp2,
  output logic                                     memValid,
  input  logic                                     memReady,
  output logic [$clog2(DEPTH)-1:0]                 memTag,
  output logic [OPC_W-1:0]                         memOpcode,
  output logic [DATA_W-1:0]                        memOp1,
  output logic [DATA_W-1:0]                        memOp2,
  output logic                                     memIsStore,
  input  logic [NUM_WB-1:0]                        wbValid,
  input  logic [NUM_WB-1:0][$clog2(DEPTH)-1:0]     wbTag,
  input  logic [NUM_WB-1:0][DATA_W-1:0]            wbData,
  output logic                                     cmtValid,
  output logic [REG_W-1:0]                         cmtDest,
  output logic [DATA_W-1:0]                        cmtData,
  output logic                                     cmtIsStore,
  input  logic                                     killValid,
  input  logic [$clog2(DEPTH)-1:0]                 killTag
);

  localparam int IDX_W = $clog2(DEPTH);

  robStrobe_t       st;
  logic [IDX_W-1:0] headPtr;
  logic [DEPTH-1:0] aluCand, memCand, killMask;
  entState_e        headState;

  rob_ctrl #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .insValid(insValid), .killValid(killValid),
    .killTag(killTag), .aluCand(aluCand), .memCand(memCand),
    .aluReady(aluReady), .memReady(memReady), .headState(headState),
    .st(st), .tailPtr(insTag), .headPtr(headPtr), .aluPick(aluTag),
    .memPick(memTag), .aluAvail(aluValid), .memAvail(memValid),
    .killMask(killMask), .insReady(insReady), .commitNow(cmtValid)
  );

  rob_dp #(.DEPTH(DEPTH), .DATA_W(DATA_W), .REG_W(REG_W), .OPC_W(OPC_W),
           .NUM_WB(NUM_WB), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .tailPtr(insTag), .headPtr(headPtr),
    .aluPick(aluTag), .memPick(memTag), .killMask(killMask),
    .insIsMem(insIsMem), .insIsStore(insIsStore), .insDest(insDest),
    .insOpcode(insOpcode), .src1IsTag(src1IsTag), .src1Tag(src1Tag),
    .src1Val(src1Val), .src2IsTag(src2IsTag), .src2Tag(src2Tag),
    .src2Val(src2Val), .wbValid(wbValid), .wbTag(wbTag), .wbData(wbData),
    .aluCand(aluCand), .memCand(memCand), .headState(headState),
    .aluOpcode(aluOpcode), .aluOp1(aluOp1), .aluOp2(aluOp2),
    .memOpcode(memOpcode), .memOp1(memOp1), .memOp2(memOp2),
    .memIsStore(memIsStore), .cmtDest(cmtDest), .cmtData(cmtData),
    .cmtIsStore(cmtIsStore)
  );

endmodule

// File: rtl/rob_checker.sv
module rob_checker #(
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             insValid,
  input logic             insReady,
  input logic [IDX_W-1:0] insTag,
  input logic             aluValid,
  input logic             memValid,
  input logic [IDX_W-1:0] aluTag,
  input logic [IDX_W-1:0] memTag,
  input logic             cmtValid,
  input logic [IDX_W-1:0] headPtr
);

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rstN)
    !insReady |=> $stable(insTag));

  assert_tail_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (insValid && insReady) |=> (insTag == $past(insTag) + IDX_W'(1)));

  assert_ports_distinct_R4: assert property (@(posedge clk) disable iff (!rstN)
    (aluValid && memValid) |-> (aluTag != memTag));

  assert_retire_advances_R7: assert property (@(posedge clk) disable iff (!rstN)
    cmtValid |=> (headPtr == $past(headPtr) + IDX_W'(1)));

endmodule

bind rob_core rob_checker #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rstN(rstN), .insValid(insValid), .insReady(insReady),
  .insTag(insTag), .aluValid(aluValid), .memValid(memValid),
  .aluTag(aluTag), .memTag(memTag), .cmtValid(cmtValid), .headPtr(headPtr)
);

// File: tb/sim_rob_core.sv
`timescale 1ns/1ps
module sim_rob_core;

  localparam int DEPTH = 8, DATA_W = 16, REG_W = 5, OPC_W = 6, NUM_WB = 2;
  localparam int IDX_W = $clog2(DEPTH);

  logic clk = 1'b0, rstN = 1'b0;
  logic insValid = 0, insIsMem = 0, insIsStore = 0;
  logic [REG_W-1:0] insDest = '0;
  logic [OPC_W-1:0] insOpcode = '0;
  logic src1IsTag = 0, src2IsTag = 0;
  logic [IDX_W-1:0] src1Tag = '0, src2Tag = '0;
  logic [DATA_W-1:0] src1Val = '0, src2Val = '0;
  logic insReady; logic [IDX_W-1:0] insTag;
  logic aluValid, aluReady = 0; logic [IDX_W-1:0] aluTag;
  logic [OPC_W-1:0] aluOpcode; logic [DATA_W-1:0] aluOp1, aluOp2;
  logic memValid, memReady = 0; logic [IDX_W-1:0] memTag;
  logic [OPC_W-1:0] memOpcode; logic [DATA_W-1:0] memOp1, memOp2;
  logic memIsStore;
  logic [NUM_WB-1:0] wbValid = '0;
  logic [NUM_WB-1:0][IDX_W-1:0] wbTag = '0;
  logic [NUM_WB-1:0][DATA_W-1:0] wbData = '0;
  logic cmtValid, cmtIsStore; logic [REG_W-1:0] cmtDest; logic [DATA_W-1:0] cmtData;
  logic killValid = 0; logic [IDX_W-1:0] killTag = '0;

  always #5 clk = ~clk;

  rob_core #(.DEPTH(DEPTH), .DATA_W(DATA_W), .REG_W(REG_W), .OPC_W(OPC_W),
             .NUM_WB(NUM_WB)) u0 (.*);

  typedef struct { logic [REG_W-1:0] d; logic [DATA_W-1:0] v; logic s; } exp_t;
  exp_t expQ[$];
  int total = 0, bad = 0;
  bit done = 0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic setIns(input logic mem, input logic store, input int dest,
                        input logic t1, input int a, input logic t2, input int b);
    insValid = 1; insIsMem = mem; insIsStore = store;
    insDest = REG_W'(dest); insOpcode = OPC_W'(dest + 1);
    src1IsTag = t1; src1Tag = IDX_W'(a); src1Val = DATA_W'(a);
    src2IsTag = t2; src2Tag = IDX_W'(b); src2Val = DATA_W'(b);
  endtask

  task automatic clrIns(); insValid = 0; endtask

  task automatic setWb(input int p, input int tg, input int data);
    wbValid[p] = 1'b1; wbTag[p] = IDX_W'(tg); wbData[p] = DATA_W'(data);
  endtask

  task automatic clrWb(); wbValid = '0; endtask

  task automatic expect_commit(input int d, input int v, input logic s);
    exp_t e;
    e.d = REG_W'(d); e.v = DATA_W'(v); e.s = s;
    expQ.push_back(e);
  endtask

  // Monitor: compares every retirement against the scoreboard
  always @(negedge clk) begin
    if (rstN && cmtValid) begin
      if (expQ.size() == 0) begin
        total++; bad++;
        $display("FAIL R8 unexpected retire actual=%0d expected=none", cmtDest);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        chk("R7", "cmtDest", 32'(cmtDest), 32'(e.d));
        chk("R7", "cmtData", 32'(cmtData), 32'(e.v));
        chk("R7", "cmtIsStore", 32'(cmtIsStore), 32'(e.s));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    // R1 reset state
    chk("R1", "insReady", 32'(insReady), 1);
    chk("R1", "aluValid", 32'(aluValid), 0);
    chk("R1", "memValid", 32'(memValid), 0);
    chk("R1", "cmtValid", 32'(cmtValid), 0);
    chk("R1", "insTag", 32'(insTag), 0);

    // Single ALU instruction through its full life
    setIns(0, 0, 1, 0, 3, 0, 4);
    chk("R2", "insTag before", 32'(insTag), 0);
    tick(); clrIns();
    chk("R2", "insTag after", 32'(insTag), 1);
    chk("R4", "aluValid", 32'(aluValid), 1);
    chk("R4", "aluTag", 32'(aluTag), 0);
    chk("R4", "aluOp1", 32'(aluOp1), 3);
    chk("R4", "aluOp2", 32'(aluOp2), 4);
    tick();
    chk("R9", "held aluValid", 32'(aluValid), 1);
    chk("R9", "held aluTag", 32'(aluTag), 0);
    aluReady = 1; tick(); aluReady = 0;
    chk("R4", "not reoffered", 32'(aluValid), 0);
    setWb(0, 0, 7); expect_commit(1, 7, 0); tick(); clrWb(); tick();

    // Dependency through a tag, resolved by broadcast
    setIns(0, 0, 2, 0, 5, 0, 6); tick();
    setIns(0, 0, 3, 1, 1, 0, 2); tick(); clrIns();
    chk("R4", "oldest first", 32'(aluTag), 1);
    aluReady = 1; tick(); aluReady = 0;
    chk("R4", "tagged operand withheld", 32'(aluValid), 0);
    setWb(1, 1, 11); expect_commit(2, 11, 0); tick(); clrWb();
    chk("R5", "dependent offered", 32'(aluValid), 1);
    chk("R5", "dependent tag", 32'(aluTag), 2);
    chk("R5", "forwarded op1", 32'(aluOp1), 11);
    chk("R5", "kept op2", 32'(aluOp2), 2);
    aluReady = 1; tick(); aluReady = 0;
    setWb(0, 2, 13); expect_commit(3, 13, 0); tick(); clrWb(); tick();

    // Store and in-order retirement
    setIns(1, 1, 0, 0, 8, 0, 9); tick();
    setIns(0, 0, 4, 0, 1, 0, 1); tick(); clrIns();
    chk("R4", "memValid", 32'(memValid), 1);
    chk("R4", "memTag", 32'(memTag), 3);
    chk("R4", "memIsStore", 32'(memIsStore), 1);
    chk("R4", "alu tag", 32'(aluTag), 4);
    aluReady = 1; memReady = 1; tick(); aluReady = 0; memReady = 0;
    setWb(0, 4, 20); tick(); clrWb();
    chk("R7", "younger waits", 32'(cmtValid), 0);
    setWb(1, 3, 30); expect_commit(0, 30, 1); expect_commit(4, 20, 0);
    tick(); clrWb(); tick(); tick();

    // Same-cycle writeback and dependent insert
    setIns(0, 0, 5, 0, 2, 0, 2); tick(); clrIns();
    aluReady = 1; tick(); aluReady = 0;
    setWb(0, 5, 40); expect_commit(5, 40, 0);
    setIns(0, 0, 6, 1, 5, 0, 1); tick(); clrWb(); clrIns();
    chk("R6", "bypass offered", 32'(aluValid), 1);
    chk("R6", "bypass tag", 32'(aluTag), 6);
    chk("R6", "bypass op1", 32'(aluOp1), 40);
    aluReady = 1; tick(); aluReady = 0;
    setWb(0, 6, 41); expect_commit(6, 41, 0); tick(); clrWb(); tick(); tick();

    // Misprediction squash across pointer wrap
    setIns(0, 0, 7, 0, 1, 0, 2); tick();
    setIns(0, 0, 8, 0, 3, 0, 4); tick();
    setIns(1, 0, 9, 0, 5, 0, 6); tick();
    setIns(0, 0, 10, 1, 0, 0, 1); tick(); clrIns();
    chk("R2", "wrapped insTag", 32'(insTag), 3);
    aluReady = 1; tick(); tick(); aluReady = 0;
    killValid = 1; killTag = 3'd7; #1;
    chk("R8", "insReady during kill", 32'(insReady), 0);
    tick(); killValid = 0;
    chk("R8", "squashed mem not offered", 32'(memValid), 0);
    setWb(1, 0, 55); tick(); clrWb();
    chk("R8", "squashed dependent not offered", 32'(aluValid), 0);
    setWb(0, 7, 60); expect_commit(7, 60, 0); tick(); clrWb();
    repeat (5) tick();
    chk("R8", "drained insReady", 32'(insReady), 1);
    chk("R8", "tail kept", 32'(insTag), 3);

    // Fill to capacity, reject one, drain oldest first
    for (int k = 0; k < DEPTH - 1; k++) begin
      setIns(0, 0, 11 + k, 0, k, 0, k + 1); tick();
    end
    clrIns();
    chk("R3", "insReady when full", 32'(insReady), 0);
    setIns(0, 0, 31, 0, 9, 0, 9); tick(); clrIns();
    chk("R3", "insTag unchanged", 32'(insTag), 2);
    for (int k = 0; k < DEPTH - 1; k++) begin
      chk("R4", "drain valid", 32'(aluValid), 1);
      chk("R4", "drain order", 32'(aluTag), 32'((3 + k) % DEPTH));
      chk("R4", "drain op1", 32'(aluOp1), 32'(k));
      aluReady = 1; tick(); aluReady = 0;
      setWb(0, (3 + k) % DEPTH, 100 + k); expect_commit(11 + k, 100 + k, 0);
      tick(); clrWb();
    end
    tick();
    chk("R3", "rejected insert never issued", 32'(aluValid), 0);
    repeat (4) tick();
    chk("R7", "all retirements seen", 32'(expQ.size()), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule